// File: doc/BRIEF.md
# SCSI pseudo-DMA REQ/ACK handshake

This block paces byte transfers between a host (a CPU polling a flag, or an external DMA engine) and a SCSI bus. The host first selects a transfer direction by writing to one of three start-command indices, then sets the DMA mode bit. From then on, each byte that the bus target offers or wants is announced by the bus REQ line. The block watches REQ and ACK as they appear on the bus. It filters them against skew, then raises a DMA request flag toward the host once REQ is high and ACK is still low.

The host answers the request by accessing the data register. In send mode that access is a write; in initiator-receive mode it is a read. The access makes the block drive ACK and drop its request. The block holds ACK until the bus shows REQ gone while ACK is still high. It then releases ACK, and the next REQ starts the next byte. In the initiator role the ACK drive also carries a manual ACK bit from software. In the target role the block drives no ACK at all.

Clearing the DMA mode bit ends the transfer. It withdraws any pending request and any generated ACK, and it forgets the selected direction. Entering DMA mode clears the data-bus-enable bit. Software loads that bit through a write to index 1, and it is brought out as an output.

Top module: `pdma_handshake`

## Requirements
- R1: After reset, ack_drive, dma_req, stat_dma and data_drive_en are all 0.
- R2: A host write to index 5 selects send, index 6 selects target receive and index 7 selects initiator receive, whatever the written data. Writes to indices 0 to 4 leave the selected operation unchanged.
- R3: A write to index 1 loads data_drive_en from bit 0 of host_wdata. A rise of mode_dma (entering DMA-active) clears data_drive_en.
- R4: Bus REQ/ACK levels are acted on only once they have been stable for DESKEW_CYC cycles after synchronisation. A REQ pulse shorter than that raises no request. Stable REQ=1 with ACK=0 while DMA-active sets dma_req.
- R5: While DMA-active, a settled bus state with REQ=0 clears dma_req.
- R6: In send mode, a host write to index 0 while dma_req is 1 asserts ack_drive and clears dma_req at the next clock.
- R7: In initiator-receive mode, a host read of index 0 while dma_req is 1 asserts ack_drive and clears dma_req at the next clock.
- R8: A data-register access asserts no ACK in three cases: when it does not match the selected operation (target receive, or the wrong direction), when it addresses another index, or when no request is pending.
- R9: A settled bus state of REQ=1 with ACK=1 leaves dma_req at 0. A settled state of ACK=1 with REQ=0 releases the generated ACK and clears dma_req.
- R10: When mode_dma falls (leaving DMA-active), dma_req and the generated ACK clear and the operation returns to none. After re-entry with no new start command, data-register accesses generate no ACK.
- R11: With mode_target=0, ack_drive is the OR of man_ack and the generated ACK. With mode_target=1, ack_drive is 0.
- R12: stat_dma is 1 exactly while a DMA request is pending in DMA-active state, and 0 outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | REQ level seen on the SCSI bus (asynchronous) |
| bus_ack | input | 1 | ACK level seen on the SCSI bus, own drive included (asynchronous) |
| host_wr | input | 1 | Host register write strobe, one cycle |
| host_rd | input | 1 | Host register read strobe, one cycle |
| host_addr | input | 3 | Register index of the host access |
| host_wdata | input | 8 | Host write data; bit 0 used at index 1 only |
| mode_dma | input | 1 | DMA mode bit; high enters DMA-active state |
| mode_target | input | 1 | Role bit: 1 target, 0 initiator |
| man_ack | input | 1 | Manual ACK bit from software |
| ack_drive | output | 1 | ACK drive toward the bus |
| dma_req | output | 1 | DMA request flag toward the host |
| stat_dma | output | 1 | Status bit: request pending while DMA-active |
| data_drive_en | output | 1 | Data-bus-enable bit |

## Verification
The bench sends a one-cycle REQ glitch. A design without the stability filter would raise a request on it. The bench also holds REQ and ACK high together after the host access, where a design acting on levels instead of settled changes would re-raise the request at once. The bench issues data-register accesses of the wrong direction, at the wrong index, under target receive and after a mode exit. A design that ignored the selected operation, or failed to forget it on exit, would drive ACK there. Finally the bench drops mode_dma while ACK is held. A design that kept its generated ACK would then hang the bus.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    OP_READY = 2'd0,
    OP_SEND  = 2'd1,
    OP_TRECV = 2'd2,
    OP_IRECV = 2'd3
  } pdma_op_e;

  localparam logic [IDX_W-1:0] IDX_DATA  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ICMD  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_SEND  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_TRECV = 3'd6;
  localparam logic [IDX_W-1:0] IDX_IRECV = 3'd7;

  // settled bus pair, {req, ack}
  localparam logic [1:0] BUS_IDLE    = 2'b00;
  localparam logic [1:0] BUS_REQ     = 2'b10;
  localparam logic [1:0] BUS_BOTH    = 2'b11;
  localparam logic [1:0] BUS_ACKONLY = 2'b01;
endpackage

// File: rtl/pdma_rst_sync.sv
module pdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sh_q[STAGES-1];
endmodule

// File: rtl/pdma_deskew.sv
module pdma_deskew #(
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DESKEW_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  output logic [LINES-1:0] settled,
  output logic             settle_pulse
);
  localparam int CNT_W = $clog2(DESKEW_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DESKEW_CYC);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(DESKEW_CYC - 1);

  logic [LINES-1:0] sync_val;
  logic [LINES-1:0] prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             changed;

  // per-line synchroniser chain
  for (genvar g = 0; g < LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-2:0], line_in[g]};
    end
    assign sync_val[g] = sh_q[SYNC_STAGES-1];
  end

  assign changed = (sync_val != prev_q);

  always_comb begin
    if (changed)              cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cnt_q  <= CNT_MAX;
    end else begin
      prev_q <= sync_val;
      cnt_q  <= cnt_d;
    end
  end

  // one pulse once the lines have held still long enough after a change
  assign settle_pulse = !changed && (cnt_q == CNT_FIRE);
  assign settled      = prev_q;
endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
  import pdma_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [IDX_W-1:0]  host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              mode_dma,
  input  logic              mode_target,
  input  logic              man_ack,
  input  logic [1:0]        bus_settled,
  input  logic              settle_pulse,
  output logic              ack_drive,
  output logic              dma_req,
  output logic              stat_dma,
  output logic              data_drive_en,
  output logic              active_o,
  output pdma_op_e          op_o
);
  logic     active_q;
  pdma_op_e op_q, op_d;
  logic     req_q, req_d;
  logic     dack_q, dack_d;
  logic     dben_q, dben_d;
  logic     op_we, dben_we, hs_we;
  logic     enter, leave, xfer;
  logic     wdata_unused;

  assign wdata_unused = ^host_wdata[DATA_W-1:1];

  assign enter = mode_dma && !active_q;
  assign leave = !mode_dma && active_q;

  assign xfer = active_q && req_q && (host_addr == IDX_DATA) &&
                (((op_q == OP_SEND)  && host_wr) ||
                 ((op_q == OP_IRECV) && host_rd));

  // operation selector
  always_comb begin
    op_we = leave;
    op_d  = op_q;
    if (host_wr) begin
      case (host_addr)
        IDX_SEND:  begin op_d = OP_SEND;  op_we = 1'b1; end
        IDX_TRECV: begin op_d = OP_TRECV; op_we = 1'b1; end
        IDX_IRECV: begin op_d = OP_IRECV; op_we = 1'b1; end
        default:   ;
      endcase
    end
    if (leave) op_d = OP_READY;
  end

  // data-bus-enable bit
  always_comb begin
    dben_we = enter || (host_wr && host_addr == IDX_ICMD);
    dben_d  = host_wdata[0];
    if (enter) dben_d = 1'b0;
  end

  // request / acknowledge handshake
  always_comb begin
    req_d  = req_q;
    dack_d = dack_q;
    if (active_q && settle_pulse) begin
      case (bus_settled)
        BUS_REQ:     req_d = 1'b1;
        BUS_ACKONLY: begin req_d = 1'b0; dack_d = 1'b0; end
        default:     req_d = 1'b0;
      endcase
    end
    if (xfer) begin
      req_d  = 1'b0;
      dack_d = 1'b1;
    end
    if (leave) begin
      req_d  = 1'b0;
      dack_d = 1'b0;
    end
    hs_we = (active_q && settle_pulse) || xfer || leave;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      op_q     <= OP_READY;
      req_q    <= 1'b0;
      dack_q   <= 1'b0;
      dben_q   <= 1'b0;
    end else begin
      active_q <= mode_dma;
      if (op_we)   op_q   <= op_d;
      if (dben_we) dben_q <= dben_d;
      if (hs_we) begin
        req_q  <= req_d;
        dack_q <= dack_d;
      end
    end
  end

  assign ack_drive     = !mode_target && (man_ack || (active_q && dack_q));
  assign dma_req       = req_q;
  assign stat_dma      = req_q && active_q;
  assign data_drive_en = dben_q;
  assign active_o      = active_q;
  assign op_o          = op_q;
endmodule

// File: rtl/pdma_handshake.sv
module pdma_handshake
  import pdma_pkg::*;
#(
  parameter int DESKEW_CYC  = 3,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_ack,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [IDX_W-1:0]  host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              mode_dma,
  input  logic              mode_target,
  input  logic              man_ack,
  output logic              ack_drive,
  output logic              dma_req,
  output logic              stat_dma,
  output logic              data_drive_en
);
  logic       rst_sync_n;
  logic [1:0] bus_settled;
  logic       settle_pulse;
  logic       dma_active;
  pdma_op_e   cur_op;

  pdma_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  pdma_deskew #(
    .LINES       (2),
    .SYNC_STAGES (SYNC_STAGES),
    .DESKEW_CYC  (DESKEW_CYC)
  ) u_deskew (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .line_in      ({bus_req, bus_ack}),
    .settled      (bus_settled),
    .settle_pulse (settle_pulse)
  );

  pdma_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .host_wr       (host_wr),
    .host_rd       (host_rd),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .mode_dma      (mode_dma),
    .mode_target   (mode_target),
    .man_ack       (man_ack),
    .bus_settled   (bus_settled),
    .settle_pulse  (settle_pulse),
    .ack_drive     (ack_drive),
    .dma_req       (dma_req),
    .stat_dma      (stat_dma),
    .data_drive_en (data_drive_en),
    .active_o      (dma_active),
    .op_o          (cur_op)
  );
endmodule

// File: rtl/pdma_handshake_chk.sv
module pdma_handshake_chk
  import pdma_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_rd,
  input logic [IDX_W-1:0] host_addr,
  input logic             mode_dma,
  input logic             mode_target,
  input logic             man_ack,
  input logic [1:0]       bus_settled,
  input logic             settle_pulse,
  input logic             dma_active,
  input pdma_op_e         cur_op,
  input logic             ack_drive,
  input logic             dma_req,
  input logic             data_drive_en
);
  // R6: send-mode write answers a pending request
  a_r6_send_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_active && mode_dma && dma_req && cur_op == OP_SEND &&
     host_wr && host_addr == IDX_DATA)
    |=> (!dma_req && (ack_drive || mode_target)));

  // R7: initiator-receive read answers a pending request
  a_r7_irecv_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_active && mode_dma && dma_req && cur_op == OP_IRECV &&
     host_rd && host_addr == IDX_DATA)
    |=> (!dma_req && (ack_drive || mode_target)));

  // R9: ACK-only bus state releases the generated ACK
  a_r9_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_active && mode_dma && !dma_req && settle_pulse &&
     bus_settled == BUS_ACKONLY)
    |=> (!dma_req && (!ack_drive || man_ack)));

  // R4: a request only follows a settled REQ-without-ACK
  a_r4_req_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(settle_pulse && bus_settled == BUS_REQ));

  // R10: leaving DMA-active withdraws request and operation
  a_r10_leave_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_active) |-> (!dma_req && cur_op == OP_READY));

  // R3: entering DMA-active clears the data-bus-enable bit
  a_r3_dben_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_active) |-> !data_drive_en);
endmodule

bind pdma_handshake pdma_handshake_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .host_wr       (host_wr),
  .host_rd       (host_rd),
  .host_addr     (host_addr),
  .mode_dma      (mode_dma),
  .mode_target   (mode_target),
  .man_ack       (man_ack),
  .bus_settled   (bus_settled),
  .settle_pulse  (settle_pulse),
  .dma_active    (dma_active),
  .cur_op        (cur_op),
  .ack_drive     (ack_drive),
  .dma_req       (dma_req),
  .data_drive_en (data_drive_en)
);

// File: tb/pdma_handshake_tb.sv
module pdma_handshake_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 12;

  logic       clk;
  logic       rst_n;
  logic       bus_req, ext_ack, bus_ack;
  logic       host_wr, host_rd;
  logic [2:0] host_addr;
  logic [7:0] host_wdata;
  logic       mode_dma, mode_target, man_ack;
  logic       ack_drive, dma_req, stat_dma, data_drive_en;

  int n_checks = 0;
  int n_fails  = 0;

  assign bus_ack = ack_drive | ext_ack;

  pdma_handshake u_dut (
    .clk (clk), .rst_n (rst_n), .bus_req (bus_req), .bus_ack (bus_ack),
    .host_wr (host_wr), .host_rd (host_rd), .host_addr (host_addr),
    .host_wdata (host_wdata), .mode_dma (mode_dma),
    .mode_target (mode_target), .man_ack (man_ack),
    .ack_drive (ack_drive), .dma_req (dma_req), .stat_dma (stat_dma),
    .data_drive_en (data_drive_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (50000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_addr = '0; host_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0; host_addr = '0;
  endtask

  task automatic bus_quiet();
    bus_req = 1'b0; ext_ack = 1'b0;
    cyc(SETTLE); cyc(SETTLE);
  endtask

  task automatic t_reset();
    chk("R1 ack_drive", ack_drive, 1'b0);
    chk("R1 dma_req", dma_req, 1'b0);
    chk("R1 stat_dma", stat_dma, 1'b0);
    chk("R1 data_drive_en", data_drive_en, 1'b0);
  endtask

  task automatic t_dben();
    wr(3'd1, 8'h01);
    chk("R3 index1 load", data_drive_en, 1'b1);
    mode_dma = 1'b1;
    cyc(2);
    chk("R3 cleared on DMA entry", data_drive_en, 1'b0);
  endtask

  task automatic t_send();
    wr(3'd5, 8'hA5);
    bus_req = 1'b1; cyc(SETTLE);
    chk("R4 request on REQ", dma_req, 1'b1);
    chk("R12 status pending", stat_dma, 1'b1);
    wr(3'd0, 8'h33);
    chk("R6 send ack", ack_drive, 1'b1);
    chk("R6 request cleared", dma_req, 1'b0);
    cyc(SETTLE);
    chk("R9 REQ+ACK no request", dma_req, 1'b0);
    chk("R9 ack held", ack_drive, 1'b1);
    bus_req = 1'b0; cyc(SETTLE);
    chk("R9 ack released", ack_drive, 1'b0);
    chk("R9 request clear", dma_req, 1'b0);
    bus_quiet();
  endtask

  task automatic t_glitch();
    bus_req = 1'b1; @(negedge clk);
    bus_req = 1'b0; cyc(SETTLE);
    chk("R4 glitch filtered", dma_req, 1'b0);
  endtask

  task automatic t_drop();
    bus_req = 1'b1; cyc(SETTLE);
    chk("R5 request set", dma_req, 1'b1);
    bus_req = 1'b0; cyc(SETTLE);
    chk("R5 REQ dropped clears", dma_req, 1'b0);
    chk("R5 no ack", ack_drive, 1'b0);
  endtask

  task automatic t_irecv();
    wr(3'd7, 8'h00);
    bus_req = 1'b1; cyc(SETTLE);
    rd(3'd0);
    chk("R7 read ack", ack_drive, 1'b1);
    chk("R7 request cleared", dma_req, 1'b0);
    bus_req = 1'b0; cyc(SETTLE);
    chk("R9 irecv release", ack_drive, 1'b0);
    bus_quiet();
  endtask

  task automatic t_wrong();
    wr(3'd6, 8'hFF);
    bus_req = 1'b1; cyc(SETTLE);
    chk("R8 request pending", dma_req, 1'b1);
    wr(3'd0, 8'h11);
    rd(3'd0);
    chk("R8 target receive no ack", ack_drive, 1'b0);
    chk("R8 request kept", dma_req, 1'b1);
    wr(3'd7, 8'h00);
    wr(3'd2, 8'hFF);
    wr(3'd0, 8'h22);
    chk("R2 op kept, write no ack", ack_drive, 1'b0);
    rd(3'd3);
    chk("R8 wrong index no ack", ack_drive, 1'b0);
    rd(3'd0);
    chk("R2 irecv selected ack", ack_drive, 1'b1);
    bus_quiet();
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h44);
    chk("R8 no pending no ack", ack_drive, 1'b0);
  endtask

  task automatic t_leave();
    wr(3'd5, 8'h00);
    bus_req = 1'b1; cyc(SETTLE);
    wr(3'd0, 8'h55);
    chk("R10 ack before exit", ack_drive, 1'b1);
    mode_dma = 1'b0; @(negedge clk);
    chk("R10 ack cleared on exit", ack_drive, 1'b0);
    chk("R10 request cleared on exit", dma_req, 1'b0);
    chk("R12 status idle", stat_dma, 1'b0);
    bus_quiet();
    mode_dma = 1'b1; @(negedge clk);
    bus_req = 1'b1; cyc(SETTLE);
    chk("R10 request after re-entry", dma_req, 1'b1);
    wr(3'd0, 8'h66);
    chk("R10 op forgotten no ack", ack_drive, 1'b0);
    bus_quiet();
  endtask

  task automatic t_manual();
    man_ack = 1'b1; @(negedge clk);
    chk("R11 manual ack", ack_drive, 1'b1);
    mode_target = 1'b1; @(negedge clk);
    chk("R11 target role no ack", ack_drive, 1'b0);
    man_ack = 1'b0; mode_target = 1'b0; @(negedge clk);
    chk("R11 manual off", ack_drive, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; ext_ack = 1'b0;
    host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_wdata = '0;
    mode_dma = 1'b0; mode_target = 1'b0; man_ack = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_dben();
    t_send();
    t_glitch();
    t_drop();
    t_irecv();
    t_wrong();
    t_leave();
    t_manual();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule